// File: doc/BRIEF.md
# Peripheral Interrupt Expansion Controller

This controller takes single-cycle event strobes from a large set of peripheral sources and folds them onto a small number of CPU interrupt priority levels. Each source owns a sticky flag bit. The flag is set by its event and is removed only by a software clear strobe. A source takes part in arbitration only while both its flag and its enable bit are set. Sources are grouped in blocks of `SLOTS` per level. Level `l` (0-based) holds sources `l*SLOTS` to `l*SLOTS+SLOTS-1`.

When a level has at least one flagged, enabled source, and no earlier request on that level is still unanswered, the controller drives that level's active-low request line low for a fixed two-cycle pulse. The CPU answers with an acknowledge strobe that carries an address code naming the level. The controller then marks the level as answered and captures a vector into its vector register. The vector identifies the lowest-numbered flagged, enabled source of that level. If no such source exists, a zero phantom vector is captured instead. The register keeps its value until the next decoded acknowledge, so software reads it before it allows further interrupts.

Top module: `pie_ctrl`

## Requirements
- R1: The event strobe `evt_i[s]` sets `flag_o[s]` at the next clock edge. The flag stays set, whatever `en_i[s]` is, until a clear strobe `clr_i[s]` arrives without an event. If an event and a clear strobe arrive in the same cycle, the flag ends up set.
- R2: A source requests service only while its flag and its enable bit are both set. Enabling a source whose flag is already set starts a pulse on its level at the next edge. A flagged source that is disabled causes no pulse.
- R3: A further event on a source whose flag is still set changes nothing. It produces no extra pulse while its level is awaiting acknowledge.
- R4: While a level has an unacknowledged request, further requests on that level produce no new pulse.
- R5: A request pulse drives `irq_n_o[l]` low for exactly 2 clock cycles. After an event strobe on an enabled source of an idle level, the line is low from the second clock edge after the strobe cycle.
- R6: An acknowledge is decoded only when `ack_i` is 1 and `ack_addr_i` equals `2*(l+1)` for a level index `l` in 0 to 5. Any other address, or `ack_i` at 0, changes neither the vector nor any level's state.
- R7: On a decoded acknowledge of level `l`, `vec_o` takes the value `0x0040 + s` at the next edge, where `s` is the global index of the lowest-numbered source of that level that is both flagged and enabled.
- R8: If the acknowledged level has no flagged, enabled source, `vec_o` becomes the phantom value `0x0000`.
- R9: `vec_o` holds its value until the next decoded acknowledge.
- R10: An acknowledge marks its level as answered. If the level still has a flagged, enabled source, a new pulse starts at the second edge after the acknowledge cycle. If it has none, no pulse follows.
- R11: Levels are independent. Simultaneous requests on different levels pulse their own lines in the same cycles.
- R12: The vector is chosen from the flag state before the acknowledge edge. A clear strobe in the acknowledge cycle does not change the captured vector. An event in that cycle does not change it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 48 | Per-source event strobes |
| en_i | input | 48 | Per-source enable bits |
| clr_i | input | 48 | Per-source software flag-clear strobes |
| ack_i | input | 1 | CPU acknowledge strobe |
| ack_addr_i | input | 16 | Address code carried by the acknowledge |
| irq_n_o | output | 6 | Active-low request pulse per CPU level |
| vec_o | output | 16 | Captured vector register |
| flag_o | output | 48 | Readable per-source flag bits |

## Verification
The two functions that can fall in the same cycle are the acknowledge-time vector capture and a change to the flags of the acknowledged level, made either by a software clear strobe or by a fresh event. The bench provokes both cases by driving the clear or event strobe in the same cycle as the acknowledge strobe. The captured vector is judged against the flags as they stood before that edge. For a cleared sole source, the vector must still name that source and no follow-up pulse may appear. For an event on an empty level, the phantom value is captured and a normal pulse follows.

// File: rtl/pie_pkg.sv
`timescale 1ns/1ps
package pie_pkg;
    localparam int unsigned DEF_LEVELS    = 6;
    localparam int unsigned DEF_SLOTS     = 8;
    localparam int unsigned DEF_ADDR_W    = 16;
    localparam int unsigned DEF_VEC_W     = 16;
    localparam int unsigned DEF_VEC_BASE  = 32'h0040;
    localparam int unsigned DEF_ADDR_STEP = 2;
    localparam int unsigned DEF_PULSE_LEN = 2;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pie_flag_bank.sv
`timescale 1ns/1ps
module pie_flag_bank #(
    parameter int unsigned NSRC = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] req_o
);
    typedef struct packed {
        logic [NSRC-1:0] flag;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set dominates a simultaneous clear so an event is never lost
        st_d.flag = (st_q.flag & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign req_o  = st_q.flag & en_i;

    p_flag_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.flag & ~clr_i) & ~st_q.flag) == '0));
    p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> (($past(evt_i) & ~st_q.flag) == '0));
endmodule

// File: rtl/pie_level.sv
`timescale 1ns/1ps
module pie_level #(
    parameter int unsigned SLOTS     = 8,
    parameter int unsigned PULSE_LEN = 2,
    localparam int unsigned SW       = pie_pkg::idx_w(SLOTS),
    localparam int unsigned CW       = $clog2(PULSE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] req_i,
    input  logic             ack_hit_i,
    output logic             irq_n_o,
    output logic             pend_o,
    output logic [SW-1:0]    win_o
);
    typedef struct packed {
        logic          outst;
        logic [CW-1:0] cnt;
    } lvl_t;

    lvl_t st_d, st_q;
    logic pend;
    logic [SW-1:0] win;

    // fixed priority: lowest slot wins
    always_comb begin
        win = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (req_i[i]) win = SW'(i);
        end
    end

    assign pend = |req_i;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CW'(1);
        if (ack_hit_i) begin
            st_d.outst = 1'b0;
        end else if (pend && !st_q.outst && (st_q.cnt == '0)) begin
            st_d.outst = 1'b1;
            st_d.cnt   = CW'(PULSE_LEN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_n_o = (st_q.cnt == '0);
    assign pend_o  = pend;
    assign win_o   = win;

    p_pulse_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |=> (!irq_n_o ##1 irq_n_o));
    p_single_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> !$past(st_q.outst));
    p_pulse_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(|req_i));
endmodule

// File: rtl/pie_ack_decode.sv
`timescale 1ns/1ps
module pie_ack_decode #(
    parameter int unsigned LEVELS    = 6,
    parameter int unsigned SLOTS     = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned VEC_W     = 16,
    parameter int unsigned VEC_BASE  = 32'h0040,
    parameter int unsigned ADDR_STEP = 2,
    localparam int unsigned SW       = pie_pkg::idx_w(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_i,
    input  logic [ADDR_W-1:0]    ack_addr_i,
    input  logic [LEVELS-1:0]    pend_i,
    input  logic [LEVELS*SW-1:0] win_i,
    output logic [LEVELS-1:0]    hit_o,
    output logic [VEC_W-1:0]     vec_o
);
    typedef struct packed {
        logic [VEC_W-1:0] vec;
    } vreg_t;

    vreg_t st_d, st_q;
    logic [LEVELS-1:0] hit;

    for (genvar l = 0; l < LEVELS; l++) begin : g_dec
        assign hit[l] = ack_i && (ack_addr_i == ADDR_W'(ADDR_STEP * (l + 1)));
    end

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < LEVELS; l++) begin
            if (hit[l]) begin
                if (pend_i[l])
                    st_d.vec = VEC_W'(VEC_BASE + l * SLOTS + int'(win_i[l*SW +: SW]));
                else
                    st_d.vec = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = hit;
    assign vec_o = st_q.vec;

    p_one_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    p_phantom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hit) && !(|(hit & pend_i))) |=> (st_q.vec == '0));
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> $stable(st_q.vec));
endmodule

// File: rtl/pie_ctrl.sv
`timescale 1ns/1ps
module pie_ctrl #(
    parameter int unsigned LEVELS    = pie_pkg::DEF_LEVELS,
    parameter int unsigned SLOTS     = pie_pkg::DEF_SLOTS,
    parameter int unsigned ADDR_W    = pie_pkg::DEF_ADDR_W,
    parameter int unsigned VEC_W     = pie_pkg::DEF_VEC_W,
    parameter int unsigned VEC_BASE  = pie_pkg::DEF_VEC_BASE,
    parameter int unsigned ADDR_STEP = pie_pkg::DEF_ADDR_STEP,
    parameter int unsigned PULSE_LEN = pie_pkg::DEF_PULSE_LEN,
    localparam int unsigned NSRC     = LEVELS * SLOTS,
    localparam int unsigned SW       = pie_pkg::idx_w(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic [NSRC-1:0]   en_i,
    input  logic [NSRC-1:0]   clr_i,
    input  logic              ack_i,
    input  logic [ADDR_W-1:0] ack_addr_i,
    output logic [LEVELS-1:0] irq_n_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [NSRC-1:0]   flag_o
);
    logic [NSRC-1:0]      req;
    logic [LEVELS-1:0]    pend;
    logic [LEVELS-1:0]    hit;
    logic [LEVELS*SW-1:0] win;

    pie_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .en_i   (en_i),
        .clr_i  (clr_i),
        .flag_o (flag_o),
        .req_o  (req)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        pie_level #(.SLOTS(SLOTS), .PULSE_LEN(PULSE_LEN)) u_level (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req[l*SLOTS +: SLOTS]),
            .ack_hit_i (hit[l]),
            .irq_n_o   (irq_n_o[l]),
            .pend_o    (pend[l]),
            .win_o     (win[l*SW +: SW])
        );
    end

    pie_ack_decode #(
        .LEVELS(LEVELS), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .ADDR_STEP(ADDR_STEP)
    ) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_i      (ack_i),
        .ack_addr_i (ack_addr_i),
        .pend_i     (pend),
        .win_i      (win),
        .hit_o      (hit),
        .vec_o      (vec_o)
    );
endmodule

// File: tb/pie_ctrl_bench.sv
`timescale 1ns/1ps
module pie_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] evt = '0, en = '0, clr = '0;
    logic        ack = 1'b0;
    logic [15:0] addr = '0;
    logic [5:0]  irq_n;
    logic [15:0] vec;
    logic [47:0] flag;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pie_ctrl u_pie_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .clr_i(clr),
        .ack_i(ack), .ack_addr_i(addr), .irq_n_o(irq_n), .vec_o(vec), .flag_o(flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic do_reset();
        evt = '0; en = '0; clr = '0; ack = 1'b0; addr = '0;
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    endtask

    task automatic fire(input int s); evt[s] = 1'b1; tick(); evt = '0; endtask
    task automatic clear(input int s); clr[s] = 1'b1; tick(); clr = '0; endtask
    task automatic do_ack(input logic [15:0] a); ack = 1'b1; addr = a; tick(); ack = 1'b0; addr = '0; endtask

    task automatic t_reset_and_flags();
        do_reset();
        chk("R1 reset irq", irq_n, 6'h3F);
        chk("R1 reset vec", vec, 16'h0);
        chk("R1 reset flags", flag, 48'h0);
        fire(3);
        chk("R1 flag set while disabled", flag[3], 1'b1);
        for (int i = 0; i < 3; i++) begin
            chk("R2 disabled source no pulse", irq_n[0], 1'b1);
            tick();
        end
        chk("R1 flag held", flag[3], 1'b1);
        en[3] = 1'b1; tick();
        chk("R2 enable flagged source pulses", irq_n[0], 1'b0);
        clr[3] = 1'b1; evt[3] = 1'b1; tick(); clr = '0; evt = '0;
        chk("R1 set beats clear", flag[3], 1'b1);
        clear(3);
        chk("R1 cleared", flag[3], 1'b0);
    endtask

    task automatic t_pulse_ack();
        do_reset();
        en = '1;
        fire(10);
        chk("R5 not yet low", irq_n[1], 1'b1);
        tick(); chk("R5 low cycle 1", irq_n[1], 1'b0);
        tick(); chk("R5 low cycle 2", irq_n[1], 1'b0);
        tick(); chk("R5 released", irq_n[1], 1'b1);
        fire(10);
        for (int i = 0; i < 3; i++) begin
            chk("R3 repeat event ignored", irq_n[1], 1'b1);
            tick();
        end
        fire(12);
        for (int i = 0; i < 3; i++) begin
            chk("R4 outstanding blocks pulse", irq_n[1], 1'b1);
            tick();
        end
        do_ack(16'd4);
        chk("R7 lowest source vector", vec, 16'h004A);
        chk("R10 gap after ack", irq_n[1], 1'b1);
        tick(); chk("R10 re-pulse still pending", irq_n[1], 1'b0);
        tick(); tick();
        do_ack(16'd3);
        chk("R6 bad address vector kept", vec, 16'h004A);
        ack = 1'b0; addr = 16'd4; tick(); addr = '0;
        chk("R9 ack low vector kept", vec, 16'h004A);
        for (int i = 0; i < 2; i++) begin
            chk("R6 bad ack no re-pulse", irq_n[1], 1'b1);
            tick();
        end
        do_ack(16'd12);
        chk("R8 phantom empty level", vec, 16'h0000);
        clear(10);
        do_ack(16'd4);
        chk("R7 next source vector", vec, 16'h004C);
        tick(); tick(); tick();
        chk("R9 vector held", vec, 16'h004C);
    endtask

    task automatic t_levels();
        do_reset();
        en = '1;
        evt[0] = 1'b1; evt[47] = 1'b1; tick(); evt = '0;
        tick();
        chk("R11 two levels together", irq_n, 6'b011110);
        tick(); tick();
        chk("R11 both released", irq_n, 6'h3F);
    endtask

    task automatic t_collide();
        do_reset();
        en = '1;
        fire(20);
        tick(); tick(); tick();
        clr[20] = 1'b1; ack = 1'b1; addr = 16'd6; tick();
        clr = '0; ack = 1'b0; addr = '0;
        chk("R12 clear with ack keeps vector", vec, 16'h0054);
        chk("R12 flag cleared", flag[20], 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk("R10 no re-pulse when empty", irq_n[2], 1'b1);
            tick();
        end
        evt[24] = 1'b1; ack = 1'b1; addr = 16'd8; tick();
        evt = '0; ack = 1'b0; addr = '0;
        chk("R12 event with ack gives phantom", vec, 16'h0000);
        tick();
        chk("R12 pulse after event", irq_n[3], 1'b0);
    endtask

    initial begin
        t_reset_and_flags();
        t_pulse_ack();
        t_levels();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule